// File: doc/BRIEF.md
# Nibble-to-Byte Bus Adapter

This block sits between a host that addresses memory in 4-bit nibbles and a byte-wide command port. The host opens a burst by giving a direction, a starting nibble address and a nibble count. After that, it streams nibbles in or out, one per handshake. On the port side, every access is a single byte transaction with a request/acknowledge pair. The byte address is always the nibble address with its lowest bit dropped.

Reads fetch one byte per nibble and hand back the half that the low address bit selects. Writes take one of two paths.

- **Packed write:** when the burst still has two or more nibbles and the current address is even, two host nibbles go out together as one byte write.
- **Merged write:** in every other case, the adapter first reads the byte at that address from the port. It replaces the addressed half with the host nibble and then writes the byte back. The half that is kept comes from whatever the port returns in its current read mode, not from an independent copy of the array.

When the burst ends, a one-cycle done pulse is raised and the adapter accepts a new command.

Top module: `nb_adapter`

## Requirements
- R1: After reset, port_req, rd_valid, wr_ready and done are 0 and cmd_ready is 1.
- R2: Every port access uses byte address = nibble address >> 1, so the byte that changes (or is read) is the one holding the addressed nibble.
- R3: A read burst of N nibbles makes exactly N port reads. The nibble returned for an even address is port_rdata[3:0], and for an odd address it is port_rdata[7:4]. The address steps by one per beat.
- R4: When at least two nibbles remain and the address is even, the next two host nibbles become one port write with the first nibble in bits [3:0] and the second in [7:4]. No port read is made for them, and the address advances by two.
- R5: Any other write nibble costs one port read followed by one port write. The written byte holds the host nibble in the addressed half (even: [3:0], odd: [7:4]) and the read byte's other half unchanged.
- R6: port_req stays high with port_addr, port_we and port_wdata stable until the cycle port_ack is seen, and it is low in the following cycle.
- R7: done is high for exactly one cycle after the last beat of a burst, and cmd_ready is 1 when done is high.
- R8: A command with length 0 makes no port access and still produces the done pulse.
- R9: cmd_ready is 0 for the whole time a burst is in progress.
- R10: Once rd_valid is high, rd_valid and rd_nib hold steady until rd_ready is sampled high. In the cycle after that handshake, rd_valid is 0.
- R11: wr_ready is high only while a write burst is waiting for a host nibble. It is 0 when idle and during read bursts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Adapter idle, command accepted |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_addr | input | NA_W | Starting nibble address |
| cmd_len | input | LEN_W | Nibble count of the burst |
| wr_valid | input | 1 | Host write nibble offered |
| wr_ready | output | 1 | Adapter takes the write nibble |
| wr_nib | input | NIB_W | Host write nibble |
| rd_valid | output | 1 | Read nibble available |
| rd_ready | input | 1 | Host takes the read nibble |
| rd_nib | output | NIB_W | Read nibble |
| done | output | 1 | One-cycle end-of-burst pulse |
| port_req | output | 1 | Byte access request |
| port_we | output | 1 | 1 = byte write, 0 = byte read |
| port_addr | output | NA_W-1 | Byte address |
| port_wdata | output | 2*NIB_W | Byte write data |
| port_ack | input | 1 | Access completed |
| port_rdata | input | 2*NIB_W | Byte read data, valid with port_ack |

## Verification
The in-RTL assertions check the cycle-level rules on every cycle:

- request hold and release on the port (R6);
- read-nibble hold and its single-beat completion (R10);
- the done pulse width (R7);
- the kept half of a merged byte matching the fetched byte (R5).

Other behaviour is visible only across a whole burst, so only the bench's scenarios can show it. This covers the choice between the packed and merged paths, which the bench observes through its counts of port reads and writes (R4, R5). It also covers the resulting memory image, including odd starts, single nibbles and zero lengths (R2, R8). Finally, it covers the nibble order returned by read bursts (R3).

// File: rtl/nb_pkg.sv
package nb_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_RREQ,
    S_RWAIT,
    S_ROUT,
    S_WGET0,
    S_WGET1,
    S_WFETCH,
    S_WFWAIT,
    S_WPUT,
    S_WWAIT,
    S_FIN
  } seq_state_t;

endpackage

// File: rtl/nb_lane.sv
// Half selection and half replacement on one byte.
module nb_lane #(
  parameter int NIB_W = 4
) (
  input  logic [2*NIB_W-1:0] byte_i,
  input  logic [NIB_W-1:0]   nib_i,
  input  logic               odd_i,
  output logic [NIB_W-1:0]   sel_o,
  output logic [2*NIB_W-1:0] merged_o
);

  localparam int LANES = 2;

  assign sel_o = odd_i ? byte_i[NIB_W +: NIB_W] : byte_i[0 +: NIB_W];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic LANE_ODD = (i == 1);
    assign merged_o[i*NIB_W +: NIB_W] =
      (odd_i == LANE_ODD) ? nib_i : byte_i[i*NIB_W +: NIB_W];
  end

endmodule

// File: rtl/nb_port_if.sv
// Single-beat request/acknowledge engine on the byte port.
module nb_port_if #(
  parameter int BA_W   = 7,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              we_i,
  input  logic [BA_W-1:0]   addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              fin_o,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              port_req,
  output logic              port_we,
  output logic [BA_W-1:0]   port_addr,
  output logic [BYTE_W-1:0] port_wdata,
  input  logic              port_ack,
  input  logic [BYTE_W-1:0] port_rdata
);

  always_ff @(posedge clk) begin
    if (rst) begin
      port_req   <= 1'b0;
      port_we    <= 1'b0;
      port_addr  <= '0;
      port_wdata <= '0;
      rdata_o    <= '0;
      fin_o      <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (!port_req && start_i) begin
        port_req   <= 1'b1;
        port_we    <= we_i;
        port_addr  <= addr_i;
        port_wdata <= wdata_i;
      end else if (port_req && port_ack) begin
        port_req <= 1'b0;
        fin_o    <= 1'b1;
        if (!port_we) rdata_o <= port_rdata;
      end
    end
  end

  // R6: request and its payload hold until acknowledged
  a_r6_req_hold: assert property (@(posedge clk) disable iff (rst)
    (port_req && !port_ack) |=> (port_req && $stable(port_addr) &&
                                 $stable(port_we) && $stable(port_wdata)));

  // R6: request drops right after the acknowledge
  a_r6_req_drop: assert property (@(posedge clk) disable iff (rst)
    (port_req && port_ack) |=> !port_req);

endmodule

// File: rtl/nb_seq.sv
// Burst sequencer: chooses packed or merged writes, steps reads.
module nb_seq
  import nb_pkg::*;
#(
  parameter int NA_W  = 8,
  parameter int LEN_W = 6,
  parameter int NIB_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cmd_valid,
  output logic               cmd_ready,
  input  logic               cmd_write,
  input  logic [NA_W-1:0]    cmd_addr,
  input  logic [LEN_W-1:0]   cmd_len,
  input  logic               wr_valid,
  output logic               wr_ready,
  input  logic [NIB_W-1:0]   wr_nib,
  output logic               rd_valid,
  input  logic               rd_ready,
  output logic [NIB_W-1:0]   rd_nib,
  output logic               done,
  output logic               start_o,
  output logic               we_o,
  output logic [NA_W-2:0]    baddr_o,
  output logic [2*NIB_W-1:0] wbyte_o,
  input  logic               fin_i,
  input  logic [2*NIB_W-1:0] rdata_i
);

  localparam int BYTE_W = 2 * NIB_W;

  seq_state_t          st;
  logic [NA_W-1:0]     cur_addr;
  logic [LEN_W-1:0]    remain;
  logic [NIB_W-1:0]    nib0;
  logic [BYTE_W-1:0]   wbyte;
  logic                pair;
  logic [NIB_W-1:0]    lane_sel;
  logic [BYTE_W-1:0]   lane_merged;
  logic [LEN_W-1:0]    step;
  logic                pair_ok;

  nb_lane #(.NIB_W(NIB_W)) u_lane (
    .byte_i   (rdata_i),
    .nib_i    (nib0),
    .odd_i    (cur_addr[0]),
    .sel_o    (lane_sel),
    .merged_o (lane_merged)
  );

  assign cmd_ready = (st == S_IDLE);
  assign wr_ready  = (st == S_WGET0) || (st == S_WGET1);
  assign start_o   = (st == S_RREQ) || (st == S_WFETCH) || (st == S_WPUT);
  assign we_o      = (st == S_WPUT);
  assign baddr_o   = cur_addr[NA_W-1:1];
  assign wbyte_o   = wbyte;
  assign step      = pair ? LEN_W'(2) : LEN_W'(1);
  assign pair_ok   = (remain >= LEN_W'(2)) && !cur_addr[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      cur_addr <= '0;
      remain   <= '0;
      nib0     <= '0;
      wbyte    <= '0;
      pair     <= 1'b0;
      rd_valid <= 1'b0;
      rd_nib   <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: begin
          if (cmd_valid) begin
            cur_addr <= cmd_addr;
            remain   <= cmd_len;
            if (cmd_len == '0)   st <= S_FIN;
            else if (cmd_write)  st <= S_WGET0;
            else                 st <= S_RREQ;
          end
        end
        S_RREQ:  st <= S_RWAIT;
        S_RWAIT: begin
          if (fin_i) begin
            rd_nib   <= lane_sel;
            rd_valid <= 1'b1;
            st       <= S_ROUT;
          end
        end
        S_ROUT: begin
          if (rd_ready) begin
            rd_valid <= 1'b0;
            cur_addr <= cur_addr + NA_W'(1);
            remain   <= remain - LEN_W'(1);
            st       <= (remain == LEN_W'(1)) ? S_FIN : S_RREQ;
          end
        end
        S_WGET0: begin
          if (wr_valid) begin
            nib0 <= wr_nib;
            st   <= pair_ok ? S_WGET1 : S_WFETCH;
          end
        end
        S_WGET1: begin
          if (wr_valid) begin
            wbyte <= {wr_nib, nib0};
            pair  <= 1'b1;
            st    <= S_WPUT;
          end
        end
        S_WFETCH: st <= S_WFWAIT;
        S_WFWAIT: begin
          if (fin_i) begin
            wbyte <= lane_merged;
            pair  <= 1'b0;
            st    <= S_WPUT;
          end
        end
        S_WPUT:  st <= S_WWAIT;
        S_WWAIT: begin
          if (fin_i) begin
            cur_addr <= cur_addr + NA_W'(step);
            remain   <= remain - step;
            st       <= (remain == step) ? S_FIN : S_WGET0;
          end
        end
        S_FIN: begin
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R10: offered read nibble holds until taken
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_nib)));

  // R10: one nibble per handshake
  a_r10_rd_single: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready) |=> !rd_valid);

  // R7: done lasts one cycle
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: merged byte keeps the fetched byte's other half
  a_r5_keep_half: assert property (@(posedge clk) disable iff (rst)
    (st == S_WFWAIT && fin_i && !cur_addr[0]) |=>
      (wbyte[NIB_W +: NIB_W] == $past(rdata_i[NIB_W +: NIB_W])));

  a_r5_keep_half_odd: assert property (@(posedge clk) disable iff (rst)
    (st == S_WFWAIT && fin_i && cur_addr[0]) |=>
      (wbyte[0 +: NIB_W] == $past(rdata_i[0 +: NIB_W])));

  // R11: no write nibble accepted during a read burst
  a_r11_no_wr_in_read: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> !wr_ready);

endmodule

// File: rtl/nb_adapter.sv
module nb_adapter #(
  parameter int NA_W  = 8,
  parameter int LEN_W = 6,
  parameter int NIB_W = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_valid,
  output logic                 cmd_ready,
  input  logic                 cmd_write,
  input  logic [NA_W-1:0]      cmd_addr,
  input  logic [LEN_W-1:0]     cmd_len,
  input  logic                 wr_valid,
  output logic                 wr_ready,
  input  logic [NIB_W-1:0]     wr_nib,
  output logic                 rd_valid,
  input  logic                 rd_ready,
  output logic [NIB_W-1:0]     rd_nib,
  output logic                 done,
  output logic                 port_req,
  output logic                 port_we,
  output logic [NA_W-2:0]      port_addr,
  output logic [2*NIB_W-1:0]   port_wdata,
  input  logic                 port_ack,
  input  logic [2*NIB_W-1:0]   port_rdata
);

  localparam int BA_W   = NA_W - 1;
  localparam int BYTE_W = 2 * NIB_W;

  logic              start_s;
  logic              we_s;
  logic [BA_W-1:0]   baddr_s;
  logic [BYTE_W-1:0] wbyte_s;
  logic              fin_s;
  logic [BYTE_W-1:0] rdata_s;

  nb_seq #(.NA_W(NA_W), .LEN_W(LEN_W), .NIB_W(NIB_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_len   (cmd_len),
    .wr_valid  (wr_valid),
    .wr_ready  (wr_ready),
    .wr_nib    (wr_nib),
    .rd_valid  (rd_valid),
    .rd_ready  (rd_ready),
    .rd_nib    (rd_nib),
    .done      (done),
    .start_o   (start_s),
    .we_o      (we_s),
    .baddr_o   (baddr_s),
    .wbyte_o   (wbyte_s),
    .fin_i     (fin_s),
    .rdata_i   (rdata_s)
  );

  nb_port_if #(.BA_W(BA_W), .BYTE_W(BYTE_W)) u_port (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_s),
    .we_i       (we_s),
    .addr_i     (baddr_s),
    .wdata_i    (wbyte_s),
    .fin_o      (fin_s),
    .rdata_o    (rdata_s),
    .port_req   (port_req),
    .port_we    (port_we),
    .port_addr  (port_addr),
    .port_wdata (port_wdata),
    .port_ack   (port_ack),
    .port_rdata (port_rdata)
  );

  // R9: no command taken while a port access is open
  a_r9_busy: assert property (@(posedge clk) disable iff (rst)
    port_req |-> !cmd_ready);

endmodule

// File: tb/nb_adapter_tb.sv
module nb_adapter_tb;

  localparam int NA_W  = 8;
  localparam int LEN_W = 6;
  localparam int NIB_W = 4;
  localparam int NBYTE = 1 << (NA_W - 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [NA_W-1:0] cmd_addr = '0;
  logic [LEN_W-1:0] cmd_len = '0;
  logic wr_valid = 1'b0;
  logic [NIB_W-1:0] wr_nib = '0;
  logic rd_ready = 1'b0;
  logic port_ack = 1'b0;
  logic [7:0] port_rdata = '0;
  logic cmd_ready, wr_ready, rd_valid, done, port_req, port_we;
  logic [NIB_W-1:0] rd_nib;
  logic [NA_W-2:0] port_addr;
  logic [7:0] port_wdata;

  int checks = 0, fails = 0;
  int n_rd = 0, n_wr = 0, hold_bad = 0;
  logic [7:0] mem [NBYTE];
  logic [7:0] exp_mem [NBYTE];

  always #10 clk = ~clk;

  nb_adapter #(.NA_W(NA_W), .LEN_W(LEN_W), .NIB_W(NIB_W)) u_dut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_len(cmd_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_nib(wr_nib),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_nib(rd_nib), .done(done),
    .port_req(port_req), .port_we(port_we), .port_addr(port_addr),
    .port_wdata(port_wdata), .port_ack(port_ack), .port_rdata(port_rdata)
  );

  task automatic chk(input bit ok, input string req, input longint act,
                     input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] model_nib(input int a);
    return a[0] ? exp_mem[a >> 1][7:4] : exp_mem[a >> 1][3:0];
  endfunction

  // Expected port traffic for a write burst (R4/R5)
  function automatic int exp_writes(input int a, input int n);
    int w = 0;
    while (n > 0) begin
      if (n >= 2 && a[0] == 1'b0) begin a += 2; n -= 2; end
      else begin a += 1; n -= 1; end
      w++;
    end
    return w;
  endfunction

  function automatic int exp_reads(input int a, input int n);
    int r = 0;
    while (n > 0) begin
      if (n >= 2 && a[0] == 1'b0) begin a += 2; n -= 2; end
      else begin a += 1; n -= 1; r++; end
    end
    return r;
  endfunction

  // Port responder: random latency, checks request hold (R6)
  initial begin : responder
    int lat = 0;
    bit seen = 0;
    logic [NA_W-2:0] a0;
    logic [7:0] d0;
    logic w0;
    forever begin
      @(negedge clk);
      if (port_ack) port_ack = 1'b0;
      else if (port_req) begin
        if (!seen) begin
          seen = 1; a0 = port_addr; d0 = port_wdata; w0 = port_we;
          lat = $urandom % 3;
        end
        if (port_addr != a0 || port_wdata != d0 || port_we != w0) hold_bad++;
        if (lat == 0) begin
          if (port_we) begin mem[port_addr] = port_wdata; n_wr++; end
          else begin port_rdata = mem[port_addr]; n_rd++; end
          port_ack = 1'b1;
          seen = 0;
        end else lat--;
      end
    end
  end

  task automatic issue(input bit w, input int a, input int n);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = w;
    cmd_addr = NA_W'(a); cmd_len = LEN_W'(n);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_addr = '1;
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
    chk(cmd_ready == 1'b1, "R7 ready with done", cmd_ready, 1);
    @(negedge clk);
    chk(done == 1'b0, "R7 done one cycle", done, 0);
  endtask

  task automatic do_write(input int a, input int n);
    int r0 = n_rd, w0 = n_wr;
    bit mem_ok = 1;
    issue(1'b1, a, n);
    for (int i = 0; i < n; i++) begin
      logic [3:0] v = 4'($urandom);
      for (int k = 0; k < int'($urandom % 3); k++) @(negedge clk);
      wr_valid = 1'b1; wr_nib = v;
      while (!wr_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      wr_valid = 1'b0;
      if ((a + i) % 2 == 1) exp_mem[(a + i) >> 1][7:4] = v;
      else exp_mem[(a + i) >> 1][3:0] = v;
    end
    wait_done();
    for (int b = 0; b < NBYTE; b++) if (mem[b] !== exp_mem[b]) mem_ok = 0;
    chk(mem_ok, "R2 R5 memory image after write", mem_ok, 1);
    chk(n_wr - w0 == exp_writes(a, n), "R4 port write count",
        n_wr - w0, exp_writes(a, n));
    chk(n_rd - r0 == exp_reads(a, n), "R5 port read count",
        n_rd - r0, exp_reads(a, n));
  endtask

  task automatic do_read(input int a, input int n);
    int r0 = n_rd, w0 = n_wr;
    bit ok_nib = 1, ok_hold = 1;
    issue(1'b0, a, n);
    for (int i = 0; i < n; i++) begin
      logic [3:0] got;
      while (!rd_valid) @(negedge clk);
      got = rd_nib;
      if (i == 0) begin
        chk(cmd_ready == 1'b0, "R9 busy during burst", cmd_ready, 0);
        chk(wr_ready == 1'b0, "R11 no wr_ready in read", wr_ready, 0);
      end
      for (int k = 0; k < int'($urandom % 3); k++) begin
        @(negedge clk);
        if (!rd_valid || rd_nib != got) ok_hold = 0;
      end
      if (got != model_nib(a + i)) begin
        ok_nib = 0;
        $display("FAIL R3 nibble at %0d actual=%0h expected=%0h",
                 a + i, got, model_nib(a + i));
        fails++; checks++;
      end
      rd_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      rd_ready = 1'b0;
    end
    wait_done();
    chk(ok_nib, "R3 read nibbles", ok_nib, 1);
    chk(ok_hold, "R10 read hold", ok_hold, 1);
    chk(n_rd - r0 == n && n_wr == w0, "R3 one port read per nibble",
        n_rd - r0, n);
  endtask

  task automatic do_zero(input bit w, input int a);
    int r0 = n_rd, w0 = n_wr;
    issue(w, a, 0);
    wait_done();
    chk(n_rd == r0 && n_wr == w0, "R8 zero length no access",
        (n_rd - r0) + (n_wr - w0), 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL R7 watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    int seed = 32'h1a2b;
    void'($urandom(seed));
    for (int b = 0; b < NBYTE; b++) begin
      mem[b] = 8'($urandom);
      exp_mem[b] = mem[b];
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(port_req == 0 && rd_valid == 0 && done == 0 && wr_ready == 0,
        "R1 reset outputs", {port_req, rd_valid, done, wr_ready}, 0);
    chk(cmd_ready == 1'b1, "R1 cmd_ready after reset", cmd_ready, 1);
    chk(wr_ready == 1'b0, "R11 wr_ready idle", wr_ready, 0);

    // directed corners
    do_write(10, 1);   // lone even nibble: merge into [3:0]
    do_write(21, 1);   // lone odd nibble: merge into [7:4]
    do_write(40, 2);   // one packed byte
    do_write(51, 2);   // odd start: two merged writes
    do_write(60, 5);   // pairs then a trailing single
    do_write(77, 6);   // odd head, pairs, single tail
    do_zero(1'b1, 30);
    do_zero(1'b0, 31);
    do_read(10, 1);
    do_read(21, 1);
    do_read(50, 9);
    do_write(NBYTE * 2 - 3, 3);
    do_read(NBYTE * 2 - 4, 4);

    for (int t = 0; t < 60; t++) begin
      int n = $urandom % 14;
      int a = $urandom % (NBYTE * 2 - n);
      if ($urandom % 2) do_write(a, n);
      else do_read(a, n);
    end

    chk(hold_bad == 0, "R6 request hold until ack", hold_bad, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule